// File: doc/BRIEF.md
# Host Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from up to 32 interrupt sources into a sticky status vector and drives one level-sensitive interrupt line toward a host processor. A per-source mask decides which pending events can raise that line. A 1 in a mask bit holds the event back, and a 0 lets it through. The line is asserted whenever any pending, unmasked event exists.

The host reaches the state through a small register bus with a word address, a write strobe, a read strobe and 32-bit data. The same two vectors can be accessed through several views. The mask can be written as a whole, or changed bit by bit through a set alias and a clear alias. Status can be read with no side effect, or read destructively so that everything clears. Individual status bits can also be retired through a write-one-to-acknowledge register.

Word offsets used by the bus:

| Offset | View |
|---|---|
| 0 | mask, read/write |
| 1 | mask set alias, write only |
| 2 | mask clear alias, write only |
| 3 | status peek, read only |
| 4 | status clear-on-read, read only |
| 5 | acknowledge, write only |

Offsets 6 and 7 are unused.

Implemented source bits are 0 to 10, 14, 16 and 17. Every other bit is reserved and reads as 0.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0x0000_0001 and status reads 0. The interrupt line sits at its inactive level.
- R2: A write to offset 0 replaces the mask with the written data, restricted to implemented bits. The mask changes only on a bus write.
- R3: A write to offset 1 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R4: A write to offset 2 clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A one-cycle pulse on an implemented source sets its status bit on the next clock edge. The bit stays set until it is cleared through the bus.
- R6: A read of offset 3 returns the status and changes nothing.
- R7: A read of offset 4 returns the status as it was before the read, and then clears every status bit.
- R8: A write to offset 5 clears each status bit written as 1. Bits written as 0 are unaffected.
- R9: When a source pulse arrives in the same cycle as a clear-on-read or an acknowledge of that bit, the bit ends up set.
- R10: Reserved bits (11, 12, 13, 15 and 18 to 31) never become set in status or mask, and they read as 0.
- R11: The interrupt line is the registered OR of status AND NOT mask. It follows the status and mask one clock later. With the active-low option the line is inverted.
- R12: Read data appears on the clock edge after the read strobe and holds until the next read. Reads of write-only or unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_pulse | input | 32 | One-cycle event pulses, one per source bit |
| bus_addr | input | 3 | Word offset of the register view |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Host interrupt line, polarity set by parameter |

## Verification
The hardest case to reach is a collision: a source pulse for a bit arriving in the same cycle as the clear-on-read or the acknowledge that would retire it. The bench drives the pulse and the bus strobe from one task call, so both fall on the same clock edge. It then peeks the status to confirm the bit survived and that the destructive read still returned the older value. Masked-but-pending events get the same treatment. Mask bits are toggled around a pending event to show that the line responds one cycle after each mask change, while the status itself is left untouched.

// File: rtl/host_irq_pkg.sv
// Shared definitions for the host interrupt controller: register offsets
// and the decoded access strobes passed between the decoder and the
// state registers. Assumes a word-addressed bus with 3 address bits.
package host_irq_pkg;

    localparam int unsigned HI_ADDR_W = 3;

    typedef enum logic [HI_ADDR_W-1:0] {
        OFS_MASK      = 3'd0,
        OFS_MASK_SET  = 3'd1,
        OFS_MASK_CLR  = 3'd2,
        OFS_STAT_PEEK = 3'd3,
        OFS_STAT_COR  = 3'd4,
        OFS_ACK       = 3'd5
    } hi_ofs_e;

    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic peek_rd;
        logic cor_rd;
        logic ack_wr;
    } hi_access_t;

endpackage

// File: rtl/host_irq_decode.sv
// Address decoder: turns offset plus strobes into one-hot access intents.
// Assumes the bus never raises write and read in the same cycle; when it
// does, both decoded intents are produced independently.
module host_irq_decode
    import host_irq_pkg::*;
(
    input  logic [HI_ADDR_W-1:0] addr,
    input  logic                 wr,
    input  logic                 rd,
    output hi_access_t           acc
);

    // Decode offset into per-view intent strobes.
    always_comb begin
        acc = '0;
        case (addr)
            OFS_MASK:      acc.mask_wr  = wr;
            OFS_MASK_SET:  acc.mask_set = wr;
            OFS_MASK_CLR:  acc.mask_clr = wr;
            OFS_STAT_PEEK: acc.peek_rd  = rd;
            OFS_STAT_COR:  acc.cor_rd   = rd;
            OFS_ACK:       acc.ack_wr   = wr;
            default:       acc = '0;
        endcase
    end

endmodule

// File: rtl/host_irq_mask.sv
// Mask register with direct, set-alias and clear-alias write views.
// Assumes at most one view is written per cycle (decoder guarantees it).
// Reserved bits are forced to 0 through IMPL.
module host_irq_mask
    import host_irq_pkg::*;
#(
    parameter int unsigned     W    = 32,
    parameter logic [W-1:0]    IMPL = '1,
    parameter logic [W-1:0]    RST  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hi_access_t    acc,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  mask_q
);

    logic [W-1:0] mask_d;

    // Select next mask value from the written view.
    always_comb begin
        mask_d = mask_q;
        if (acc.mask_wr)  mask_d = wdata;
        if (acc.mask_set) mask_d = mask_q | wdata;
        if (acc.mask_clr) mask_d = mask_q & ~wdata;
    end

    // Hold the mask, keeping reserved bits at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= RST & IMPL;
        else        mask_q <= mask_d & IMPL;
    end

endmodule

// File: rtl/host_irq_status.sv
// Sticky status vector. Set by one-cycle source pulses and cleared by
// acknowledge writes or a clear-on-read. A pulse in the same cycle as a
// clear keeps its bit set.
module host_irq_status
    import host_irq_pkg::*;
#(
    parameter int unsigned  W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hi_access_t    acc,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  src,
    output logic [W-1:0]  stat_q
);

    logic [W-1:0] clr_vec;

    // Build the per-bit clear request from acknowledge and clear-on-read.
    always_comb begin
        clr_vec = '0;
        if (acc.ack_wr) clr_vec = clr_vec | wdata;
        if (acc.cor_rd) clr_vec = '1;
    end

    // Update status: clear first, then let new pulses win.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_vec) | src) & IMPL;
    end

endmodule

// File: rtl/host_irq_line.sv
// Host interrupt line generator: registered OR-reduction of pending,
// unmasked status. The polarity is chosen by ACTIVE_LOW.
module host_irq_line #(
    parameter int unsigned W          = 32,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  stat,
    input  logic [W-1:0]  mask,
    output logic          irq_o
);

    logic pend_q;

    // Register whether any unmasked event is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= |(stat & ~mask);
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign irq_o = ~pend_q;
        end else begin : g_high
            assign irq_o = pend_q;
        end
    endgenerate

endmodule

// File: rtl/host_irq_ctrl.sv
// Top of the host interrupt controller. Ties the decoder, the mask and
// status registers and the line generator together, and registers read
// data one cycle after the read strobe.
module host_irq_ctrl
    import host_irq_pkg::*;
#(
    parameter int unsigned          NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0]   IMPL_BITS  = 32'h0003_47FF,
    parameter logic [NUM_SRC-1:0]   MASK_RESET = 32'h0000_0001,
    parameter bit                   ACTIVE_LOW = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_pulse,
    input  logic [HI_ADDR_W-1:0]  bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [NUM_SRC-1:0]    bus_wdata,
    output logic [NUM_SRC-1:0]    bus_rdata,
    output logic                  host_irq
);

    hi_access_t          acc;
    logic [NUM_SRC-1:0]  mask_w;
    logic [NUM_SRC-1:0]  status_w;

    host_irq_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    host_irq_mask #(.W(NUM_SRC), .IMPL(IMPL_BITS), .RST(MASK_RESET)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wdata  (bus_wdata),
        .mask_q (mask_w)
    );

    host_irq_status #(.W(NUM_SRC), .IMPL(IMPL_BITS)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wdata  (bus_wdata),
        .src    (src_pulse),
        .stat_q (status_w)
    );

    host_irq_line #(.W(NUM_SRC), .ACTIVE_LOW(ACTIVE_LOW)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (status_w),
        .mask  (mask_w),
        .irq_o (host_irq)
    );

    // Capture read data on the read strobe; write-only offsets give zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_MASK:                    bus_rdata <= mask_w;
                OFS_STAT_PEEK, OFS_STAT_COR: bus_rdata <= status_w;
                default:                     bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/host_irq_ctrl_chk.sv
// Property checker for host_irq_ctrl, attached by bind. Observes ports
// plus the mask and status vectors of the top level.
module host_irq_ctrl_chk #(
    parameter int unsigned W          = 32,
    parameter logic [W-1:0] IMPL      = '1,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  src_pulse,
    input logic [2:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [W-1:0]  status,
    input logic [W-1:0]  mask,
    input logic          host_irq
);

    logic irq_on;
    assign irq_on = ACTIVE_LOW ? ~host_irq : host_irq;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | mask) & ~IMPL) == '0);                                      // R10

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> ((status & $past(status)) == $past(status))); // R5

    AST_SOURCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_pulse & IMPL) != '0) |=>
        ((status & $past(src_pulse & IMPL)) == $past(src_pulse & IMPL)));      // R9

    AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask));                                            // R2

    AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd4 && src_pulse == '0) |=> (status == '0));   // R7

    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_on == |($past(status) & ~$past(mask))));                 // R11

endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(
    .W(NUM_SRC), .IMPL(IMPL_BITS), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .status    (status_w),
    .mask      (mask_w),
    .host_irq  (host_irq)
);

// File: tb/host_irq_ctrl_bench.sv
// Scoreboard bench: the driver computes expected read data from a
// requirement-level model and queues it; the monitor compares it on the
// cycle the design presents it.
module host_irq_ctrl_bench;

    localparam logic [31:0] IMPL = 32'h0003_47FF;
    localparam bit          ALOW = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_pulse = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_mask = 32'h1;
    logic [31:0] m_stat = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          pend = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    host_irq_ctrl u_host_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare queued read expectations against registered read data.
    always @(negedge clk) begin
        if (pend) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            pend = 1'b0;
        end
    end

    // Driver: one bus/source cycle, model update, line check.
    task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                        input logic [31:0] wd, input logic [31:0] src, input string tag);
        logic [31:0] os, om, rexp, clr;
        bit exp_irq;
        os = m_stat; om = m_mask;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; src_pulse = src;
        rexp = (a == 3'd0) ? om : ((a == 3'd3 || a == 3'd4) ? os : 32'h0);
        @(posedge clk); #1;
        clr = '0;
        if (wr && a == 3'd5) clr = wd;
        if (rd && a == 3'd4) clr = '1;
        m_stat = ((os & ~clr) | src) & IMPL;
        if (wr && a == 3'd0) m_mask = wd & IMPL;
        if (wr && a == 3'd1) m_mask = (om | wd) & IMPL;
        if (wr && a == 3'd2) m_mask = (om & ~wd) & IMPL;
        if (rd) begin exp_q.push_back(rexp); tag_q.push_back(tag); pend = 1'b1; end
        exp_irq = |(os & ~om);
        bus_wr = 0; bus_rd = 0; src_pulse = '0;
        @(negedge clk);
        check({tag, " R11 line"}, {31'd0, host_irq}, {31'd0, exp_irq ^ ALOW});
    endtask

    task automatic idle(input string tag);
        step(0, 0, 3'd0, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 line inactive", {31'd0, host_irq}, {31'd0, ALOW});
        step(0, 1, 3'd0, '0, '0, "R1 mask reset");
        step(0, 1, 3'd3, '0, '0, "R1 status reset");
        step(1, 0, 3'd0, 32'hFFFF_FFFF, '0, "R2 write all");
        step(0, 1, 3'd0, '0, '0, "R2 R10 mask readback");
        step(1, 0, 3'd2, 32'hFFFF_FFFF, '0, "R4 clear all");
        step(1, 0, 3'd1, 32'h0000_0404, '0, "R3 set");
        step(0, 1, 3'd0, '0, '0, "R3 mask readback");
        step(1, 0, 3'd2, 32'h0000_0004, '0, "R4 partial clear");
        step(0, 1, 3'd0, '0, '0, "R4 mask readback");
        step(0, 0, 3'd0, '0, 32'h0000_0402, "R5 pulse");
        idle("R5 hold");
        idle("R11 asserted");
        step(0, 1, 3'd3, '0, '0, "R6 peek 1");
        step(0, 1, 3'd3, '0, '0, "R6 peek 2");
        step(1, 0, 3'd5, 32'h0000_0002, '0, "R8 ack");
        step(0, 1, 3'd3, '0, '0, "R8 status after ack");
        idle("R11 masked pending");
        step(1, 0, 3'd2, 32'h0000_0400, '0, "R11 unmask");
        idle("R11 after unmask");
        step(1, 0, 3'd1, 32'h0000_0400, '0, "R11 remask");
        idle("R11 after remask");
        step(0, 0, 3'd0, '0, 32'hFFFF_FFFF, "R10 all sources");
        step(0, 1, 3'd3, '0, '0, "R10 reserved read 0");
        step(0, 1, 3'd4, '0, '0, "R7 cor value");
        step(0, 1, 3'd3, '0, '0, "R7 cleared");
        step(1, 0, 3'd5, 32'h0000_0020, 32'h0000_0020, "R9 ack collision");
        step(0, 1, 3'd3, '0, '0, "R9 survived ack");
        step(0, 1, 3'd4, '0, 32'h0000_0008, "R9 cor collision");
        step(0, 1, 3'd3, '0, '0, "R9 survived cor");
        step(0, 1, 3'd1, '0, '0, "R12 write-only reads 0");
        step(0, 1, 3'd5, '0, '0, "R12 ack reads 0");
        step(0, 1, 3'd7, '0, '0, "R12 unused reads 0");
        idle("R12 hold");
        check("R12 rdata held", bus_rdata, 32'h0);
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <20000", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule